// File: doc/BRIEF.md
# Slot-Table Time-Division Memory Arbiter

This block shares a memory port among fourteen requesting clients by dividing time into a repeating frame of sixty-four slots. There are two memory regions, external and internal. Each region has its own table, its own slot pointer and its own grant vector, and each arbitrates without reference to the other. Every table entry names the client that owns that slot. When the owner asks for memory in its slot it wins outright. When the owner is silent, the slot is not wasted: it goes to the lowest-numbered client that is requesting.

Software reserves bandwidth by writing table entries one at a time. Each write gives a region, a slot number and a client index. A client that owns k of the 64 entries is guaranteed at least k/64 of its region's arbitration cycles. After reset the table is filled in a rotating pattern, so that every client already has some slots before software programs anything.

Top module: `slot_arbiter`

## Requirements
- R1: After reset both slot pointers read 0, and entry s of each table holds client s mod 14, so slot 0 belongs to client 0, slot 13 to client 13 and slot 14 to client 0.
- R2: Each slot pointer advances by one on every clock edge while out of reset, and wraps from 63 to 0.
- R3: When the client named by the current slot's entry is requesting, that client alone is granted, whatever other clients request.
- R4: When the slot's owner is not requesting and at least one other client is, the requester with the lowest index is granted.
- R5: Each region's grant vector (bit i = client i) is one-hot or zero, only grants a requesting client, and is zero when no client in that region requests.
- R6: A write with the enable high stores the client index into the entry addressed by the slot number, in the region selected by the region input (0 = external, 1 = internal). Entries elsewhere in that region and the whole table of the other region are unchanged.
- R7: A write to the slot being looked up in the same cycle does not affect that cycle's grant. The new owner applies from the next visit to that slot.
- R8: A write whose client index is 14 or 15 is ignored, and the entry keeps its previous owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Table write enable |
| cfgRegion | input | 1 | Region of the write: 0 external, 1 internal |
| cfgSlot | input | 6 | Slot number written |
| cfgClient | input | 4 | Owning client index written |
| req | input | 28 | Requests; bits [13:0] external region, [27:14] internal region |
| grant | output | 28 | Grants, same layout as req |
| slotPtr | output | 12 | Current slot; bits [5:0] external, [11:6] internal |

## Verification
The assertions treat requests as sampled only at clock edges. They assume reset is released away from an edge, so that the first cycle out of reset starts at slot 0. The grant properties also rely on the table holding only valid owners, which the write filter guarantees whatever index the bench writes. The stimulus changes every input on the falling edge only. It drives request patterns that are full, empty, sparse and random. It mixes in writes that land on the slot currently under lookup and writes carrying out-of-range indices, and the reference model accepts both.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int NUM_CLIENTS = 14;
  localparam int NUM_SLOTS   = 64;
  localparam int NUM_REGIONS = 2;

  localparam int CLIENT_W = $clog2(NUM_CLIENTS);
  localparam int SLOT_W   = $clog2(NUM_SLOTS);
  localparam int REGION_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int REQ_W    = NUM_REGIONS * NUM_CLIENTS;
  localparam int PTR_W    = NUM_REGIONS * SLOT_W;

  // Strobes from control to datapath: one write strobe per region plus payload
  typedef struct packed {
    logic [NUM_REGIONS-1:0] wrStb;
    logic [SLOT_W-1:0]      wrSlot;
    logic [CLIENT_W-1:0]    wrClient;
  } tblWrite_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import slot_arb_pkg::*;
(
  input  logic                cfgWrEn,
  input  logic [REGION_W-1:0] cfgRegion,
  input  logic [SLOT_W-1:0]   cfgSlot,
  input  logic [CLIENT_W-1:0] cfgClient,
  input  logic                clk,
  input  logic                rstN,
  output tblWrite_t           wrCmd,
  output logic [PTR_W-1:0]    slotPtr
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic clientValid;
  assign clientValid = (32'(cfgClient) < NUM_CLIENTS);

  // Write decode: invalid owner indices never reach the table
  always_comb begin
    wrCmd.wrSlot   = cfgSlot;
    wrCmd.wrClient = cfgClient;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      wrCmd.wrStb[r] = cfgWrEn && clientValid && (cfgRegion == REGION_W'(r));
    end
  end

  // One free-running slot pointer per region
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_ptr
    logic [SLOT_W-1:0] ptrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  ptrQ <= '0;
      else if (ptrQ == LAST_SLOT) ptrQ <= '0;
      else                        ptrQ <= ptrQ + 1'b1;
    end
    assign slotPtr[r*SLOT_W +: SLOT_W] = ptrQ;
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import slot_arb_pkg::*;
(
  input  logic [NUM_CLIENTS-1:0] reqVec,
  input  logic [CLIENT_W-1:0]    owner,
  output logic [NUM_CLIENTS-1:0] grantVec
);
  logic [NUM_CLIENTS-1:0] ownerOh;
  logic [NUM_CLIENTS-1:0] lowestReq;
  logic                   ownerHit;

  always_comb begin
    for (int i = 0; i < NUM_CLIENTS; i++) begin
      ownerOh[i] = (owner == CLIENT_W'(i));
    end
    ownerHit  = |(ownerOh & reqVec);
    lowestReq = reqVec & (~reqVec + 1'b1);
    grantVec  = ownerHit ? ownerOh : lowestReq;
  end
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import slot_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tblWrite_t        wrCmd,
  input  logic [PTR_W-1:0] slotPtr,
  input  logic [REQ_W-1:0] req,
  output logic [REQ_W-1:0] grant
);
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic [CLIENT_W-1:0] ownerTbl [NUM_SLOTS];
    logic [CLIENT_W-1:0] curOwner;

    // Entry s resets to s mod NUM_CLIENTS
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          ownerTbl[s] <= CLIENT_W'(s % NUM_CLIENTS);
        end
      end else if (wrCmd.wrStb[r]) begin
        ownerTbl[wrCmd.wrSlot] <= wrCmd.wrClient;
      end
    end

    // Lookup reads the registered entry; a write lands after this cycle
    assign curOwner = ownerTbl[slotPtr[r*SLOT_W +: SLOT_W]];

    arb_pick u_pick (
      .reqVec   (req[r*NUM_CLIENTS +: NUM_CLIENTS]),
      .owner    (curOwner),
      .grantVec (grant[r*NUM_CLIENTS +: NUM_CLIENTS])
    );
  end
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [REGION_W-1:0] cfgRegion,
  input  logic [SLOT_W-1:0]   cfgSlot,
  input  logic [CLIENT_W-1:0] cfgClient,
  input  logic [REQ_W-1:0]    req,
  output logic [REQ_W-1:0]    grant,
  output logic [PTR_W-1:0]    slotPtr
);
  tblWrite_t wrCmd;

  arb_ctrl u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgRegion (cfgRegion),
    .cfgSlot   (cfgSlot),
    .cfgClient (cfgClient),
    .clk       (clk),
    .rstN      (rstN),
    .wrCmd     (wrCmd),
    .slotPtr   (slotPtr)
  );

  arb_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrCmd   (wrCmd),
    .slotPtr (slotPtr),
    .req     (req),
    .grant   (grant)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import slot_arb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [REQ_W-1:0] req,
  input logic [REQ_W-1:0] grant,
  input logic [PTR_W-1:0] slotPtr
);
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_chk
    logic [NUM_CLIENTS-1:0] q;
    logic [NUM_CLIENTS-1:0] g;
    logic [SLOT_W-1:0]      p;
    assign q = req[r*NUM_CLIENTS +: NUM_CLIENTS];
    assign g = grant[r*NUM_CLIENTS +: NUM_CLIENTS];
    assign p = slotPtr[r*SLOT_W +: SLOT_W];

    a_r5_onehot: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(g));
    a_r5_only_requesters: assert property (@(posedge clk) disable iff (!rstN)
      (g & ~q) == '0);
    a_r5_idle: assert property (@(posedge clk) disable iff (!rstN)
      (q == '0) |-> (g == '0));
    a_r4_no_waste: assert property (@(posedge clk) disable iff (!rstN)
      (q != '0) |-> (g != '0));
    a_r1_start: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rstN) |-> (p == '0));
    a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (p == (($past(p) == SLOT_W'(NUM_SLOTS - 1)) ? '0 : $past(p) + 1'b1)));
  end
endmodule

bind slot_arbiter arb_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .req     (req),
  .grant   (grant),
  .slotPtr (slotPtr)
);

// File: tb/test_slot_arbiter.sv
module test_slot_arbiter;
  import slot_arb_pkg::*;
  localparam int NC = NUM_CLIENTS;
  localparam int NS = NUM_SLOTS;
  localparam int NR = NUM_REGIONS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rstN;
  logic                cfgWrEn;
  logic [REGION_W-1:0] cfgRegion;
  logic [SLOT_W-1:0]   cfgSlot;
  logic [CLIENT_W-1:0] cfgClient;
  logic [REQ_W-1:0]    req;
  logic [REQ_W-1:0]    grant;
  logic [PTR_W-1:0]    slotPtr;

  slot_arbiter i_slot_arbiter (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRegion(cfgRegion),
    .cfgSlot(cfgSlot), .cfgClient(cfgClient), .req(req), .grant(grant),
    .slotPtr(slotPtr)
  );

  int tests = 0;
  int fails = 0;
  int mTbl [NR][NS];
  int mPtr [NR];

  task automatic modelReset();
    for (int r = 0; r < NR; r++) begin
      mPtr[r] = 0;
      for (int s = 0; s < NS; s++) mTbl[r][s] = s % NC;
    end
  endtask

  function automatic logic [NC-1:0] expGrant(int r, logic [NC-1:0] q);
    int owner = mTbl[r][mPtr[r]];
    if (q[owner]) return NC'(1) << owner;
    for (int i = 0; i < NC; i++) if (q[i]) return NC'(1) << i;
    return '0;
  endfunction

  task automatic step(logic [REQ_W-1:0] q, bit we, int rg, int slot, int cli, string tag);
    req       = q;
    cfgWrEn   = we;
    cfgRegion = REGION_W'(rg);
    cfgSlot   = SLOT_W'(slot);
    cfgClient = CLIENT_W'(cli);
    #2;
    for (int r = 0; r < NR; r++) begin
      logic [NC-1:0] e;
      logic [NC-1:0] a;
      e = expGrant(r, q[r*NC +: NC]);
      a = grant[r*NC +: NC];
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s region %0d slot %0d grant act %h exp %h", tag, r, mPtr[r], a, e);
      end
      tests++;
      if (slotPtr[r*SLOT_W +: SLOT_W] !== SLOT_W'(mPtr[r])) begin
        fails++;
        $display("FAIL R2 region %0d pointer act %0d exp %0d", r,
                 slotPtr[r*SLOT_W +: SLOT_W], mPtr[r]);
      end
    end
    @(posedge clk);
    if (we && cli < NC) mTbl[rg][slot] = cli;
    for (int r = 0; r < NR; r++) mPtr[r] = (mPtr[r] + 1) % NS;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  localparam logic [REQ_W-1:0] ALL = '1;

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog cycles act 20000 exp fewer");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgRegion = '0; cfgSlot = '0; cfgClient = '0; req = '0;
    modelReset();
    repeat (3) @(negedge clk);
    tests++;
    if (slotPtr !== '0 || grant !== '0) begin
      fails++;
      $display("FAIL R1 reset state ptr act %h exp 0 grant act %h exp 0", slotPtr, grant);
    end
    rstN = 1'b1;
    // R1 / R3: every client requests, so the grant reveals each slot's owner
    for (int i = 0; i < NS + 2; i++) step(ALL, 0, 0, 0, 0, "R1");
    // R5: no requests at all
    for (int i = 0; i < 4; i++) step('0, 0, 0, 0, 0, "R5");
    // R6: reprogram region 0, region 1 untouched
    for (int s = 0; s < NS; s++)
      step({ALL[NC-1:0], NC'($urandom) & NC'($urandom)}, 1, 0, s, (s * 5 + 3) % NC, "R6");
    for (int i = 0; i < NS; i++) step(ALL, 0, 0, 0, 0, "R6");
    // R7: write the slot under lookup this very cycle
    for (int i = 0; i < 8; i++) step(ALL, 1, 1, mPtr[1], (mPtr[1] + 7) % NC, "R7");
    for (int i = 0; i < NS; i++) step(ALL, 0, 0, 0, 0, "R7");
    // R8: out-of-range owner indices are dropped
    for (int i = 0; i < 16; i++) step(ALL, 1, i % 2, (i * 9) % NS, 14 + (i % 2), "R8");
    for (int i = 0; i < NS; i++) step(ALL, 0, 0, 0, 0, "R8");
    // R3/R4: sparse random requests with random valid writes
    for (int i = 0; i < 400; i++) begin
      logic [REQ_W-1:0] q;
      q = REQ_W'($urandom) & REQ_W'($urandom) & REQ_W'($urandom);
      step(q, ($urandom % 4) == 0, $urandom % NR, $urandom % NS, $urandom % NC, "R3/R4");
    end
    summary();
    $finish;
  end
endmodule